// File: doc/BRIEF.md
# Header Rule Vector Combiner

This block takes an IPv4 header arriving as a stream of 32-bit words and pulls out the five classification fields: source address, destination address, protocol, source port and destination port. It then issues the lookups that belong to it. An address/protocol lookup receives a 72-bit key. Two port lookups each receive a 16-bit key. The engines that answer these lookups sit outside the block. Each engine returns a bit vector: the address/protocol engine returns one bit per compressed entry, and each port engine returns one bit per rule.

Several rules may share one compressed entry. For that reason the entry vector is first expanded into rule positions, using a loadable table that gives, for each rule, the set of entries that feed it. The three rule vectors are then ANDed together, and the full vector of matching rules is reported with a one-cycle strobe. Overlapping rules therefore show up as several set bits at once.

For packets that are neither TCP nor UDP, no port lookup is issued. Both port vectors take a per-rule "ports unconstrained" mask instead. The block handles one header at a time. It holds `busy` high from the cycle after the first word is accepted until the result strobe.

Top module: `rvc_top`

## Requirements
- R1: In the cycle after the fifth header word (destination address) is accepted, `ip_req` pulses for one cycle and `ip_key` equals {source address, destination address, protocol}. The source address occupies bits 71:40, the destination bits 39:8 and the protocol bits 7:0. The protocol is bits 23:16 of the third word.
- R2: For TCP (protocol 6) or UDP (protocol 17), the port word is the word at index IHL, counted from 0. IHL is bits 27:24 of the first word, and values below 5 are treated as 5, so option words are skipped. In the cycle after that word, `sp_req` and `dp_req` pulse for one cycle, with `sp_key` set to bits 31:16 and `dp_key` set to bits 15:0.
- R3: The expanded bit for rule r is the OR of `ent_vec` bits over the entries set in rule r's map. A rule whose map is empty never matches.
- R4: `match_vec` is the bitwise AND of the expanded entry vector and the two port vectors. Every rule present in all three is reported, so several bits may be set.
- R5: The three results may arrive in any order, including all in the same cycle. `match_valid` pulses for exactly one cycle, in the cycle after the last of them is presented, and never earlier.
- R6: For any other protocol, no port request is issued. Both port vectors are taken as the configured "any port" mask, so only an entry result is awaited.
- R7: `busy` is high from the cycle after the first word is accepted through the `match_valid` cycle, and low in the cycle after it. A start-of-header word presented while busy is ignored: no request follows, and the pending result is unchanged.
- R8: A write with `cfg_we` stores `cfg_map` and `cfg_any` for rule `cfg_rule`. It affects every result combined after the write edge.
- R9: After reset, `busy`, `match_valid` and all requests are low, and every map and "any port" bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_valid | input | 1 | Header word valid |
| hdr_sop | input | 1 | Marks the first word of a header |
| hdr_data | input | 32 | Header word |
| busy | output | 1 | A header is in progress |
| ip_req | output | 1 | Address/protocol lookup request pulse |
| ip_key | output | 72 | {src addr, dst addr, protocol} |
| sp_req | output | 1 | Source-port lookup request pulse |
| sp_key | output | 16 | Source port |
| dp_req | output | 1 | Destination-port lookup request pulse |
| dp_key | output | 16 | Destination port |
| ent_vld | input | 1 | Entry vector result valid |
| ent_vec | input | N_ENTRIES | Compressed entry hit vector |
| sp_vld | input | 1 | Source-port result valid |
| sp_vec | input | N_RULES | Source-port rule vector |
| dp_vld | input | 1 | Destination-port result valid |
| dp_vec | input | N_RULES | Destination-port rule vector |
| cfg_we | input | 1 | Map table write enable |
| cfg_rule | input | RULE_W | Rule index written |
| cfg_map | input | N_ENTRIES | Entries that feed the rule |
| cfg_any | input | 1 | Rule places no constraint on ports |
| match_valid | output | 1 | Result strobe |
| match_vec | output | N_RULES | Matched rules |

## Verification
Each request is due exactly one cycle after the word that completes its key is captured. The result strobe is due one cycle after the last of the three lookup results is presented, and `busy` falls one cycle after that. The bench drives every input on the falling edge and checks each output on the following falling edge, at the precise cycle it is due. It also confirms the strobe is absent in the cycles between partial results, and that requests stay low wherever none is due. The expected vectors come from the bench's own copy of the configured maps, expanded by its own loop.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;
  localparam logic [3:0] IHL_MIN   = 4'd5;
  localparam logic [3:0] IDX_PROTO = 4'd2;
  localparam logic [3:0] IDX_SRC   = 4'd3;
  localparam logic [3:0] IDX_DST   = 4'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PARSE = 2'd1,
    ST_WAIT  = 2'd2
  } parse_st_t;

  function automatic logic carries_ports(input logic [7:0] proto);
    return (proto == PROTO_TCP) || (proto == PROTO_UDP);
  endfunction

  function automatic logic [3:0] port_word_idx(input logic [3:0] ihl);
    return (ihl < IHL_MIN) ? IHL_MIN : ihl;
  endfunction
endpackage

// File: rtl/rvc_hdr_parse.sv
module rvc_hdr_parse
  import rvc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_valid,
  input  logic        hdr_sop,
  input  logic [31:0] hdr_data,
  input  logic        done_i,
  output logic        start_o,
  output logic        port_skip_o,
  output logic        busy_o,
  output logic        ip_req_o,
  output logic [71:0] ip_key_o,
  output logic        sp_req_o,
  output logic [15:0] sp_key_o,
  output logic        dp_req_o,
  output logic [15:0] dp_key_o
);
  parse_st_t   st;
  logic [3:0]  idx_q;
  logic [3:0]  ihl_q;
  logic [7:0]  proto_q;
  logic [31:0] src_q;
  logic [31:0] dst_q;
  logic        take_w;
  logic        dst_evt_w;
  logic        port_evt_w;
  logic        unused_bits;

  assign unused_bits = ^{hdr_data[31:28], hdr_data[23:0]};

  assign start_o    = hdr_valid && hdr_sop && (st == ST_IDLE);
  assign take_w     = hdr_valid && (st == ST_PARSE);
  assign dst_evt_w  = take_w && (idx_q == IDX_DST);
  assign port_evt_w = take_w && (idx_q == port_word_idx(ihl_q)) && carries_ports(proto_q);
  assign busy_o     = (st != ST_IDLE);
  assign ip_key_o   = {src_q, dst_q, proto_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      idx_q       <= '0;
      ihl_q       <= '0;
      proto_q     <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      sp_key_o    <= '0;
      dp_key_o    <= '0;
      ip_req_o    <= 1'b0;
      sp_req_o    <= 1'b0;
      dp_req_o    <= 1'b0;
      port_skip_o <= 1'b0;
    end else begin
      ip_req_o    <= 1'b0;
      sp_req_o    <= 1'b0;
      dp_req_o    <= 1'b0;
      port_skip_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_o) begin
            ihl_q <= hdr_data[27:24];
            idx_q <= 4'd1;
            st    <= ST_PARSE;
          end
        end
        ST_PARSE: begin
          if (take_w) begin
            idx_q <= idx_q + 4'd1;
            if (idx_q == IDX_PROTO) proto_q <= hdr_data[23:16];
            if (idx_q == IDX_SRC)   src_q   <= hdr_data;
            if (dst_evt_w) begin
              dst_q    <= hdr_data;
              ip_req_o <= 1'b1;
              if (!carries_ports(proto_q)) begin
                port_skip_o <= 1'b1;
                st          <= ST_WAIT;
              end
            end
            if (port_evt_w) begin
              sp_key_o <= hdr_data[31:16];
              dp_key_o <= hdr_data[15:0];
              sp_req_o <= 1'b1;
              dp_req_o <= 1'b1;
              st       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (done_i) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ipreq_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ip_req_o |=> !ip_req_o);
  assert_port_only_l4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req_o || dp_req_o) |-> carries_ports(proto_q));
  assert_port_after_ip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_req_o |-> (busy_o && !ip_req_o && dp_req_o));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> busy_o);
endmodule

// File: rtl/rvc_map_table.sv
module rvc_map_table #(
  parameter  int N_RULES   = 8,
  parameter  int N_ENTRIES = 6,
  localparam int RULE_W    = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [RULE_W-1:0]    cfg_rule,
  input  logic [N_ENTRIES-1:0] cfg_map,
  input  logic                 cfg_any,
  input  logic [N_ENTRIES-1:0] ent_i,
  output logic [N_RULES-1:0]   dec_vec_o,
  output logic [N_RULES-1:0]   any_mask_o
);
  logic [N_ENTRIES-1:0] map_q [N_RULES];

  function automatic logic expand_bit(input logic [N_ENTRIES-1:0] ent,
                                      input logic [N_ENTRIES-1:0] sel);
    return |(ent & sel);
  endfunction

  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    logic hit_w;
    assign hit_w = cfg_we && (int'(cfg_rule) == r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[r]      <= '0;
        any_mask_o[r] <= 1'b0;
      end else if (hit_w) begin
        map_q[r]      <= cfg_map;
        any_mask_o[r] <= cfg_any;
      end
    end
    assign dec_vec_o[r] = expand_bit(ent_i, map_q[r]);
  end

  assert_empty_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_i == '0) |-> (dec_vec_o == '0));
endmodule

// File: rtl/rvc_collect.sv
module rvc_collect #(
  parameter int N_RULES   = 8,
  parameter int N_ENTRIES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 port_skip_i,
  input  logic [N_RULES-1:0]   any_mask_i,
  input  logic                 ent_vld,
  input  logic [N_ENTRIES-1:0] ent_vec,
  input  logic                 sp_vld,
  input  logic [N_RULES-1:0]   sp_vec,
  input  logic                 dp_vld,
  input  logic [N_RULES-1:0]   dp_vec,
  input  logic [N_RULES-1:0]   dec_vec_i,
  output logic [N_ENTRIES-1:0] ent_sel_o,
  output logic                 match_valid_o,
  output logic [N_RULES-1:0]   match_vec_o
);
  logic                 armed;
  logic                 got_e, got_s, got_d;
  logic [N_ENTRIES-1:0] ent_q;
  logic [N_RULES-1:0]   sp_q, dp_q;
  logic                 take_e, take_s, take_d, skip_w;
  logic                 got_e_n, got_s_n, got_d_n, all_n;
  logic [N_RULES-1:0]   sp_n, dp_n;

  function automatic logic [N_RULES-1:0] combine3(input logic [N_RULES-1:0] a,
                                                  input logic [N_RULES-1:0] b,
                                                  input logic [N_RULES-1:0] c);
    return a & b & c;
  endfunction

  assign skip_w  = armed && port_skip_i;
  assign take_e  = armed && ent_vld && !got_e;
  assign take_s  = armed && sp_vld && !got_s && !skip_w;
  assign take_d  = armed && dp_vld && !got_d && !skip_w;
  assign got_e_n = got_e || take_e;
  assign got_s_n = got_s || take_s || skip_w;
  assign got_d_n = got_d || take_d || skip_w;
  assign all_n   = armed && got_e_n && got_s_n && got_d_n;

  assign ent_sel_o = take_e ? ent_vec : ent_q;
  assign sp_n      = skip_w ? any_mask_i : (take_s ? sp_vec : sp_q);
  assign dp_n      = skip_w ? any_mask_i : (take_d ? dp_vec : dp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      got_e         <= 1'b0;
      got_s         <= 1'b0;
      got_d         <= 1'b0;
      ent_q         <= '0;
      sp_q          <= '0;
      dp_q          <= '0;
      match_valid_o <= 1'b0;
      match_vec_o   <= '0;
    end else begin
      match_valid_o <= 1'b0;
      if (start_i) begin
        armed <= 1'b1;
        got_e <= 1'b0;
        got_s <= 1'b0;
        got_d <= 1'b0;
      end else if (armed) begin
        got_e <= got_e_n;
        got_s <= got_s_n;
        got_d <= got_d_n;
        ent_q <= ent_sel_o;
        sp_q  <= sp_n;
        dp_q  <= dp_n;
        if (all_n) begin
          match_valid_o <= 1'b1;
          match_vec_o   <= combine3(dec_vec_i, sp_n, dp_n);
          armed         <= 1'b0;
        end
      end
    end
  end

  assert_emit_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid_o |=> !match_valid_o);
  assert_emit_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid_o |-> $past(armed));
  assert_and_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid_o |-> ((match_vec_o & ~$past(sp_n)) == '0));
endmodule

// File: rtl/rvc_top.sv
module rvc_top #(
  parameter  int N_RULES   = 8,
  parameter  int N_ENTRIES = 6,
  localparam int RULE_W    = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  input  logic                 hdr_sop,
  input  logic [31:0]          hdr_data,
  output logic                 busy,
  output logic                 ip_req,
  output logic [71:0]          ip_key,
  output logic                 sp_req,
  output logic [15:0]          sp_key,
  output logic                 dp_req,
  output logic [15:0]          dp_key,
  input  logic                 ent_vld,
  input  logic [N_ENTRIES-1:0] ent_vec,
  input  logic                 sp_vld,
  input  logic [N_RULES-1:0]   sp_vec,
  input  logic                 dp_vld,
  input  logic [N_RULES-1:0]   dp_vec,
  input  logic                 cfg_we,
  input  logic [RULE_W-1:0]    cfg_rule,
  input  logic [N_ENTRIES-1:0] cfg_map,
  input  logic                 cfg_any,
  output logic                 match_valid,
  output logic [N_RULES-1:0]   match_vec
);
  logic                 start_w;
  logic                 port_skip_w;
  logic [N_ENTRIES-1:0] ent_sel_w;
  logic [N_RULES-1:0]   dec_vec_w;
  logic [N_RULES-1:0]   any_mask_w;

  rvc_hdr_parse u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .hdr_sop    (hdr_sop),
    .hdr_data   (hdr_data),
    .done_i     (match_valid),
    .start_o    (start_w),
    .port_skip_o(port_skip_w),
    .busy_o     (busy),
    .ip_req_o   (ip_req),
    .ip_key_o   (ip_key),
    .sp_req_o   (sp_req),
    .sp_key_o   (sp_key),
    .dp_req_o   (dp_req),
    .dp_key_o   (dp_key)
  );

  rvc_map_table #(.N_RULES(N_RULES), .N_ENTRIES(N_ENTRIES)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_rule  (cfg_rule),
    .cfg_map   (cfg_map),
    .cfg_any   (cfg_any),
    .ent_i     (ent_sel_w),
    .dec_vec_o (dec_vec_w),
    .any_mask_o(any_mask_w)
  );

  rvc_collect #(.N_RULES(N_RULES), .N_ENTRIES(N_ENTRIES)) u_coll (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_w),
    .port_skip_i  (port_skip_w),
    .any_mask_i   (any_mask_w),
    .ent_vld      (ent_vld),
    .ent_vec      (ent_vec),
    .sp_vld       (sp_vld),
    .sp_vec       (sp_vec),
    .dp_vld       (dp_vld),
    .dp_vec       (dp_vec),
    .dec_vec_i    (dec_vec_w),
    .ent_sel_o    (ent_sel_w),
    .match_valid_o(match_valid),
    .match_vec_o  (match_vec)
  );

  assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> busy);
  assert_strobe_drops_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !busy);
endmodule

// File: tb/rvc_top_tb_top.sv
module rvc_top_tb_top;
  localparam int NR = 8;
  localparam int NE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_valid = 1'b0, hdr_sop = 1'b0;
  logic [31:0]   hdr_data = '0;
  logic          busy, ip_req, sp_req, dp_req, match_valid;
  logic [71:0]   ip_key;
  logic [15:0]   sp_key, dp_key;
  logic          ent_vld = 1'b0, sp_vld = 1'b0, dp_vld = 1'b0;
  logic [NE-1:0] ent_vec = '0;
  logic [NR-1:0] sp_vec = '0, dp_vec = '0, match_vec;
  logic          cfg_we = 1'b0, cfg_any = 1'b0;
  logic [2:0]    cfg_rule = '0;
  logic [NE-1:0] cfg_map = '0;

  int checks = 0;
  int fails  = 0;
  logic [NE-1:0] bmap [NR];
  logic [NR-1:0] bany = '0;

  always #10 clk = ~clk;

  rvc_top #(.N_RULES(NR), .N_ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_sop(hdr_sop),
    .hdr_data(hdr_data), .busy(busy), .ip_req(ip_req), .ip_key(ip_key),
    .sp_req(sp_req), .sp_key(sp_key), .dp_req(dp_req), .dp_key(dp_key),
    .ent_vld(ent_vld), .ent_vec(ent_vec), .sp_vld(sp_vld), .sp_vec(sp_vec),
    .dp_vld(dp_vld), .dp_vec(dp_vec), .cfg_we(cfg_we), .cfg_rule(cfg_rule),
    .cfg_map(cfg_map), .cfg_any(cfg_any), .match_valid(match_valid),
    .match_vec(match_vec)
  );

  task automatic chk(input bit ok, input string rq, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] model(input logic [NE-1:0] ev,
                                          input logic [NR-1:0] sv,
                                          input logic [NR-1:0] dv, input bit l4);
    logic [NR-1:0] res;
    for (int r = 0; r < NR; r++) begin
      logic hit;
      hit = 1'b0;
      for (int e = 0; e < NE; e++) if (ev[e] && bmap[r][e]) hit = 1'b1;
      res[r] = hit && (l4 ? (sv[r] && dv[r]) : bany[r]);
    end
    return res;
  endfunction

  task automatic cfg_write(input int rule, input logic [NE-1:0] m, input bit any);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rule = 3'(rule); cfg_map = m; cfg_any = any;
    @(negedge clk);
    cfg_we = 1'b0;
    bmap[rule] = m; bany[rule] = any;
  endtask

  task automatic after_word(input int j, input int pidx, input bit l4,
                            input logic [71:0] key, input logic [31:0] pw);
    if (j == 0) chk(busy == 1'b1, "R7 busy after first word", 72'(busy), 72'd1);
    if (j == 4) begin
      chk(ip_req == 1'b1, "R1 ip_req due", 72'(ip_req), 72'd1);
      chk(ip_key == key, "R1 ip_key", ip_key, key);
    end else chk(ip_req == 1'b0, "R1 ip_req idle", 72'(ip_req), 72'd0);
    if (l4 && j == pidx) begin
      chk(sp_req && dp_req, "R2 port req due", 72'({sp_req, dp_req}), 72'd3);
      chk({sp_key, dp_key} == pw, "R2 port keys", 72'({sp_key, dp_key}), 72'(pw));
    end else
      chk(!sp_req && !dp_req, "R2/R6 no port req", 72'({sp_req, dp_req}), 72'd0);
  endtask

  task automatic send_hdr(input logic [3:0] ihl, input logic [7:0] proto,
                          input logic [31:0] sip, input logic [31:0] dip,
                          input logic [15:0] sp, input logic [15:0] dp);
    int pidx;
    bit l4;
    logic [31:0] w;
    pidx = (ihl < 4'd5) ? 5 : int'(ihl);
    l4 = (proto == 8'd6) || (proto == 8'd17);
    for (int i = 0; i <= pidx; i++) begin
      @(negedge clk);
      if (i > 0) after_word(i - 1, pidx, l4, {sip, dip, proto}, {sp, dp});
      case (i)
        0: w = {4'h4, ihl, 8'h00, 16'd60};
        1: w = 32'h1234_4000;
        2: w = {8'd64, proto, 16'hbeef};
        3: w = sip;
        4: w = dip;
        default: w = (i == pidx) ? {sp, dp} : 32'h0101_0101;
      endcase
      hdr_valid = 1'b1; hdr_sop = (i == 0); hdr_data = w;
    end
    @(negedge clk);
    after_word(pidx, pidx, l4, {sip, dip, proto}, {sp, dp});
    hdr_valid = 1'b0; hdr_sop = 1'b0;
  endtask

  task automatic drive_one(input int which, input logic [NE-1:0] ev,
                           input logic [NR-1:0] sv, input logic [NR-1:0] dv);
    case (which)
      0: begin ent_vld = 1'b1; ent_vec = ev; end
      1: begin sp_vld = 1'b1; sp_vec = sv; end
      default: begin dp_vld = 1'b1; dp_vec = dv; end
    endcase
  endtask

  task automatic respond(input logic [NE-1:0] ev, input logic [NR-1:0] sv,
                         input logic [NR-1:0] dv, input int o0, input int o1,
                         input int o2, input bit simul, input bit l4,
                         input logic [NR-1:0] exp, input string tag);
    int n;
    n = l4 ? 3 : 1;
    if (simul) begin
      @(negedge clk);
      drive_one(0, ev, sv, dv);
      if (l4) begin drive_one(1, ev, sv, dv); drive_one(2, ev, sv, dv); end
    end else begin
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        ent_vld = 1'b0; sp_vld = 1'b0; dp_vld = 1'b0;
        if (k > 0) chk(match_valid == 1'b0, "R5 no early strobe", 72'(match_valid), 72'd0);
        drive_one(l4 ? ((k == 0) ? o0 : (k == 1) ? o1 : o2) : 0, ev, sv, dv);
      end
    end
    @(negedge clk);
    ent_vld = 1'b0; sp_vld = 1'b0; dp_vld = 1'b0;
    chk(match_valid == 1'b1, {tag, " strobe due"}, 72'(match_valid), 72'd1);
    chk(match_vec == exp, {tag, " vector"}, 72'(match_vec), 72'(exp));
    chk(busy == 1'b1, "R7 busy in strobe cycle", 72'(busy), 72'd1);
    @(negedge clk);
    chk(match_valid == 1'b0, "R5 single strobe", 72'(match_valid), 72'd0);
    chk(busy == 1'b0, "R7 busy released", 72'(busy), 72'd0);
  endtask

  task automatic t_reset;
    for (int r = 0; r < NR; r++) bmap[r] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !match_valid, "R9 reset outputs", 72'({busy, match_valid}), 72'd0);
    chk(!ip_req && !sp_req && !dp_req, "R9 reset requests", 72'({ip_req, sp_req, dp_req}), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R9 idle after reset", 72'(busy), 72'd0);
  endtask

  task automatic t_empty_map;   // R9: cleared maps block every rule
    send_hdr(4'd5, 8'd6, 32'h0a00_0001, 32'hc0a8_3202, 16'd1111, 16'd80);
    respond(6'h3f, 8'hff, 8'hff, 0, 1, 2, 1'b0, 1'b1, 8'h00, "R9/R3 empty maps");
  endtask

  task automatic t_config;      // R8
    cfg_write(0, 6'b000001, 1'b0); cfg_write(1, 6'b000011, 1'b0);
    cfg_write(2, 6'b000100, 1'b0); cfg_write(3, 6'b001000, 1'b0);
    cfg_write(4, 6'b010000, 1'b1); cfg_write(5, 6'b100000, 1'b1);
    cfg_write(6, 6'b000010, 1'b0); cfg_write(7, 6'b100100, 1'b0);
  endtask

  task automatic t_tcp_multi;   // R3 R4
    send_hdr(4'd5, 8'd6, 32'h8cfc_a0f5, 32'hc0a8_3202, 16'd146, 16'd1200);
    respond(6'b000011, 8'b1100_0011, 8'b0000_0011, 0, 1, 2, 1'b0, 1'b1,
            model(6'b000011, 8'b1100_0011, 8'b0000_0011, 1'b1), "R4 multi-match");
  endtask

  task automatic t_udp_options; // R2 R5
    send_hdr(4'd7, 8'd17, 32'h0102_0304, 32'h0506_0708, 16'd49230, 16'd60000);
    respond(6'b100100, 8'hff, 8'b1010_0000, 2, 0, 1, 1'b0, 1'b1,
            model(6'b100100, 8'hff, 8'b1010_0000, 1'b1), "R5 order dp,ent,sp");
  endtask

  task automatic t_clamp_simul; // R2 R5
    send_hdr(4'd3, 8'd6, 32'hdead_beef, 32'h1111_2222, 16'h5555, 16'haaaa);
    respond(6'h3f, 8'h5a, 8'h0f, 0, 0, 0, 1'b1, 1'b1,
            model(6'h3f, 8'h5a, 8'h0f, 1'b1), "R5 simultaneous");
  endtask

  task automatic t_non_l4;      // R6
    send_hdr(4'd5, 8'd1, 32'h0a0a_0a0a, 32'h0b0b_0b0b, 16'h1234, 16'h5678);
    respond(6'b110000, 8'h00, 8'h00, 0, 0, 0, 1'b0, 1'b0,
            model(6'b110000, 8'h00, 8'h00, 1'b0), "R6 any-port mask");
  endtask

  task automatic t_sop_busy;    // R7
    send_hdr(4'd5, 8'd6, 32'h0000_00aa, 32'h0000_00bb, 16'd7, 16'd8);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i > 0) chk(!ip_req && busy, "R7 sop ignored while busy", 72'({ip_req, busy}), 72'd1);
      hdr_valid = 1'b1; hdr_sop = (i == 0); hdr_data = (i == 0) ? 32'h4500_003c : 32'h7777_0000;
    end
    @(negedge clk);
    chk(!ip_req && busy, "R7 sop ignored while busy", 72'({ip_req, busy}), 72'd1);
    hdr_valid = 1'b0; hdr_sop = 1'b0;
    respond(6'b000001, 8'hff, 8'hff, 1, 2, 0, 1'b0, 1'b1,
            model(6'b000001, 8'hff, 8'hff, 1'b1), "R7 pending result kept");
    @(negedge clk);
    chk(!ip_req && !busy, "R7 no late start", 72'({ip_req, busy}), 72'd0);
  endtask

  task automatic t_remap;       // R8
    cfg_write(3, 6'b000001, 1'b0);
    send_hdr(4'd5, 8'd17, 32'h0909_0909, 32'h0808_0808, 16'd53, 16'd53);
    respond(6'b000001, 8'hff, 8'hff, 1, 0, 2, 1'b0, 1'b1,
            model(6'b000001, 8'hff, 8'hff, 1'b1), "R8 remapped rule");
  endtask

  initial begin
    t_reset();
    t_empty_map();
    t_config();
    t_tcp_multi();
    t_udp_options();
    t_clamp_simul();
    t_non_l4();
    t_sop_busy();
    t_remap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule